// File: doc/BRIEF.md
# Analog Converter Readout Controller

This block brings the result of a free-running analog converter into the synchronous clock domain. It offers two ways to do this, and a mode input selects between them. In ready mode the converter raises its own completion line. The controller passes that line through a flip-flop synchronizer of configurable depth. When it sees a rising edge at the synchronizer output, it latches the converter data bus.

In halt mode a start request drives a registered hold line toward the converter, for example to freeze a sample-and-hold stage. The controller then waits a programmable settle count and latches the data bus. After that it drops the hold line and returns to idle.

Either way, the captured word and a one-cycle result strobe appear together on the same clock edge. All control toward the analog side comes directly from a flip-flop. All capture logic is held in reset until a power-good input reports that the analog rails are stable.

Top module: `conv_readout`

## Requirements
- R1: While `rstN` is low, or from the first clock edge that samples `pwrGood` low, `haltOut`, `resultValid`, `overrunFlag` and `resultData` are all 0 and any halt sequence is abandoned.
- R2: In ready mode (`modeHalt` = 0), a rising edge of `anaValid` is seen after `SYNC_DEPTH` clock edges. `resultValid` and `resultData` (equal to `anaData`) update on the next edge, so the update lands `SYNC_DEPTH`+1 edges after the first edge that samples `anaValid` high.
- R3: Only a rising edge of the synchronized `anaValid` causes a capture. Holding it high yields exactly one capture, and a new capture needs the line to fall and rise again.
- R4: `resultValid` is high for exactly one cycle per capture. Between captures `resultData` holds its value.
- R5: In halt mode (`modeHalt` = 1), take the edge E0 that samples `startReq` high in idle, and let S = max(`settleCycles`, 1). `haltOut` goes high at E0. The capture (`resultValid` = 1, `resultData` = `anaData`) happens at edge E0+S+2, and `haltOut` returns low at edge E0+S+3.
- R6: A `settleCycles` value of 0 gives the same timing as a value of 1.
- R7: `startReq` sampled while a halt sequence is running (from E0+1 through E0+S+3) does not restart or extend the sequence. On the next edge `overrunFlag` pulses high for one cycle.
- R8: In halt mode, edges on `anaValid` cause no capture. In ready mode, `startReq` leaves `haltOut` low and sets no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Analog rails stable; low holds capture logic in reset |
| modeHalt | input | 1 | 0 = ready-line capture, 1 = hold-then-read capture |
| startReq | input | 1 | Starts a halt-mode sequence when idle |
| settleCycles | input | SETTLE_W | Settle wait in cycles (0 treated as 1) |
| anaValid | input | 1 | Asynchronous converter completion line |
| anaData | input | DATA_W | Converter result bus |
| haltOut | output | 1 | Registered hold request toward the converter |
| resultData | output | DATA_W | Last captured word |
| resultValid | output | 1 | One-cycle strobe with each new capture |
| overrunFlag | output | 1 | One-cycle pulse when a start arrives during a sequence |

## Verification
The properties assume that `anaData` is steady from the rise of `anaValid` until the capture edge, and for the whole time `haltOut` is high. They also assume that `pwrGood` and `modeHalt` change only between sequences, except when a power loss is deliberately injected. The stimulus drives every input at the falling clock edge. It holds the data bus constant across each capture window, and it changes the mode only while the controller is idle. The one injected power drop is placed mid-sequence so that the abandonment path is exercised.

// File: rtl/conv_readout_pkg.sv
package conv_readout_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASSERT,
    ST_SETTLE,
    ST_CAPTURE,
    ST_RELEASE
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic haltSet;
    logic haltClr;
  } dpStrobe_t;

endpackage

// File: rtl/conv_readout_dp.sv
module conv_readout_dp
  import conv_readout_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              anaValid,
  input  logic [DATA_W-1:0] anaData,
  input  dpStrobe_t         strobe,
  output logic              validRise,
  output logic              haltOut,
  output logic [DATA_W-1:0] resultData,
  output logic              resultValid
);

  localparam int LAST = SYNC_DEPTH - 1;

  generate
    if (SYNC_DEPTH < 2) begin : g_depthCheck
      $error("SYNC_DEPTH must be at least 2");
    end
  endgenerate

  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  syncPrev;

  // synchronizer chain plus one extra flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      syncPrev <= 1'b0;
    end else if (!pwrGood) begin
      syncQ    <= '0;
      syncPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_DEPTH-2:0], anaValid};
      syncPrev <= syncQ[LAST];
    end
  end

  assign validRise = syncQ[LAST] & ~syncPrev;

  // hold line toward the analog side comes straight from this flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltOut <= 1'b0;
    end else if (!pwrGood) begin
      haltOut <= 1'b0;
    end else if (strobe.haltSet) begin
      haltOut <= 1'b1;
    end else if (strobe.haltClr) begin
      haltOut <= 1'b0;
    end
  end

  // captured word and its strobe move on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData  <= '0;
      resultValid <= 1'b0;
    end else if (!pwrGood) begin
      resultData  <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobe.capture;
      if (strobe.capture) begin
        resultData <= anaData;
      end
    end
  end

endmodule

// File: rtl/conv_readout_ctrl.sv
module conv_readout_ctrl
  import conv_readout_pkg::*;
#(
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrGood,
  input  logic                modeHalt,
  input  logic                startReq,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                validRise,
  output dpStrobe_t           strobe,
  output logic                overrunFlag
);

  localparam logic [SETTLE_W-1:0] CNT_ONE = SETTLE_W'(1);

  seqState_t           state, stateNext;
  logic [SETTLE_W-1:0] settleCnt;
  logic                busy;

  assign busy = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (modeHalt) begin
          if (startReq) begin
            stateNext      = ST_ASSERT;
            strobe.haltSet = 1'b1;
          end
        end else begin
          strobe.capture = validRise;
        end
      end
      ST_ASSERT:  stateNext = ST_SETTLE;
      ST_SETTLE: begin
        if (settleCnt <= CNT_ONE) stateNext = ST_CAPTURE;
      end
      ST_CAPTURE: begin
        strobe.capture = 1'b1;
        stateNext      = ST_RELEASE;
      end
      ST_RELEASE: begin
        strobe.haltClr = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      settleCnt   <= '0;
      overrunFlag <= 1'b0;
    end else if (!pwrGood) begin
      state       <= ST_IDLE;
      settleCnt   <= '0;
      overrunFlag <= 1'b0;
    end else begin
      state       <= stateNext;
      overrunFlag <= busy & startReq;
      if (state == ST_ASSERT) begin
        settleCnt <= settleCycles;
      end else if (state == ST_SETTLE) begin
        settleCnt <= settleCnt - CNT_ONE;
      end
    end
  end

endmodule

// File: rtl/conv_readout.sv
module conv_readout
  import conv_readout_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SYNC_DEPTH = 2,
  parameter int SETTLE_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrGood,
  input  logic                modeHalt,
  input  logic                startReq,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                anaValid,
  input  logic [DATA_W-1:0]   anaData,
  output logic                haltOut,
  output logic [DATA_W-1:0]   resultData,
  output logic                resultValid,
  output logic                overrunFlag
);

  dpStrobe_t strobe;
  logic      validRise;

  conv_readout_ctrl #(
    .SETTLE_W(SETTLE_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .pwrGood      (pwrGood),
    .modeHalt     (modeHalt),
    .startReq     (startReq),
    .settleCycles (settleCycles),
    .validRise    (validRise),
    .strobe       (strobe),
    .overrunFlag  (overrunFlag)
  );

  conv_readout_dp #(
    .DATA_W    (DATA_W),
    .SYNC_DEPTH(SYNC_DEPTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pwrGood     (pwrGood),
    .anaValid    (anaValid),
    .anaData     (anaData),
    .strobe      (strobe),
    .validRise   (validRise),
    .haltOut     (haltOut),
    .resultData  (resultData),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/conv_readout_chk.sv
module conv_readout_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwrGood,
  input logic              startReq,
  input logic              haltOut,
  input logic [DATA_W-1:0] resultData,
  input logic              resultValid,
  input logic              overrunFlag
);

  a_r1_power_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> (!resultValid && !haltOut && !overrunFlag));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && $past(pwrGood) && !resultValid) |-> $stable(resultData));

  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag |-> ($past(haltOut) && $past(startReq)));

  a_r5_halt_min_width: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && $rose(haltOut)) |=> (haltOut || !pwrGood));

  a_r5_capture_under_halt: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && haltOut) |-> $past(haltOut));

endmodule

bind conv_readout conv_readout_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pwrGood     (pwrGood),
  .startReq    (startReq),
  .haltOut     (haltOut),
  .resultData  (resultData),
  .resultValid (resultValid),
  .overrunFlag (overrunFlag)
);

// File: tb/conv_readout_tb.sv
`timescale 1ns/1ps
module conv_readout_tb;

  localparam int DW = 8;
  localparam int SD = 2;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pwrGood = 1'b0;
  logic          modeHalt = 1'b0;
  logic          startReq = 1'b0;
  logic [SW-1:0] settleCycles = '0;
  logic          anaValid = 1'b0;
  logic [DW-1:0] anaData = '0;
  logic          haltOut;
  logic [DW-1:0] resultData;
  logic          resultValid;
  logic          overrunFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  conv_readout #(.DATA_W(DW), .SYNC_DEPTH(SD), .SETTLE_W(SW)) u_dut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .modeHalt(modeHalt),
    .startReq(startReq), .settleCycles(settleCycles), .anaValid(anaValid),
    .anaData(anaData), .haltOut(haltOut), .resultData(resultData),
    .resultValid(resultValid), .overrunFlag(overrunFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R2 / R4: ready-mode capture with SD+1 edge latency
  task automatic readyCapture(input logic [DW-1:0] v);
    anaData  = v;
    anaValid = 1'b1;
    for (int k = 1; k <= SD; k++) begin
      cyc();
      check("R2 no early strobe", int'(resultValid), 0);
    end
    cyc();
    check("R2 strobe at depth+1", int'(resultValid), 1);
    check("R2 captured word", int'(resultData), int'(v));
    cyc();
    check("R4 strobe one cycle", int'(resultValid), 0);
    check("R4 word held", int'(resultData), int'(v));
    anaValid = 1'b0;
    repeat (SD + 1) cyc();
  endtask

  // R5 / R6 / R7: hold-then-read sequence, checked every cycle
  task automatic haltRun(input int n, input logic [DW-1:0] v, input bit doOverrun);
    int s;
    s = (n == 0) ? 1 : n;
    modeHalt     = 1'b1;
    settleCycles = SW'(n);
    anaData      = v;
    startReq     = 1'b1;
    for (int i = 0; i <= s + 5; i++) begin
      cyc();
      if (i == 0) startReq = 1'b0;
      check((n == 0) ? "R6 halt level" : "R5 halt level", int'(haltOut), (i <= s + 2) ? 1 : 0);
      check((n == 0) ? "R6 capture timing" : "R5 capture timing", int'(resultValid), (i == s + 2) ? 1 : 0);
      if (i == s + 2) check("R5 captured word", int'(resultData), int'(v));
      check("R7 overrun pulse", int'(overrunFlag), (doOverrun && i == 2) ? 1 : 0);
      if (doOverrun && i == 1) startReq = 1'b1;
      if (doOverrun && i == 2) startReq = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int cnt;
    @(negedge clk);
    cyc();
    check("R1 reset halt", int'(haltOut), 0);
    check("R1 reset strobe", int'(resultValid), 0);
    check("R1 reset data", int'(resultData), 0);
    rstN = 1'b1;
    cyc();
    check("R1 power-good low holds", int'(resultValid | haltOut | overrunFlag), 0);
    pwrGood = 1'b1;
    repeat (3) cyc();

    // R2 sweep of data words
    for (int i = 0; i < 16; i++) readyCapture(DW'(i * 17 + 1));

    // R3 held-high line gives one capture, then again after a fall
    anaData = 8'hA5;
    anaValid = 1'b1;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      cyc();
      if (resultValid) cnt++;
    end
    check("R3 one capture while held", cnt, 1);
    anaValid = 1'b0;
    repeat (3) cyc();
    anaData = 8'h3C;
    anaValid = 1'b1;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      cyc();
      if (resultValid) cnt++;
    end
    check("R3 recapture after fall", cnt, 1);
    check("R3 new word", int'(resultData), 'h3C);
    anaValid = 1'b0;
    repeat (4) cyc();

    // R8 ready mode ignores start
    startReq = 1'b1;
    cyc();
    startReq = 1'b0;
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      cyc();
      if (haltOut || overrunFlag || resultValid) cnt++;
    end
    check("R8 start ignored in ready mode", cnt, 0);

    // R5 / R6 settle sweep
    for (int n = 0; n <= 6; n++) haltRun(n, DW'(8'h40 + n * 3), 1'b0);
    // R7 overrun during a sequence
    haltRun(4, 8'hC3, 1'b1);
    haltRun(1, 8'h19, 1'b1);

    // R8 halt mode ignores the ready line
    anaData = 8'hEE;
    anaValid = 1'b1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      cyc();
      if (resultValid) cnt++;
    end
    check("R8 ready line ignored in halt mode", cnt, 0);
    check("R8 word unchanged", int'(resultData), 'h19);
    anaValid = 1'b0;
    repeat (4) cyc();

    // R1 power loss mid-sequence abandons it
    settleCycles = 4'd5;
    anaData = 8'h77;
    startReq = 1'b1;
    cyc();
    startReq = 1'b0;
    cyc();
    cyc();
    pwrGood = 1'b0;
    cyc();
    check("R1 halt dropped on power loss", int'(haltOut), 0);
    check("R1 data cleared on power loss", int'(resultData), 0);
    pwrGood = 1'b1;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      cyc();
      if (resultValid || haltOut) cnt++;
    end
    check("R1 sequence abandoned", cnt, 0);

    // back to ready mode after halt mode
    modeHalt = 1'b0;
    repeat (2) cyc();
    readyCapture(8'h5A);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule